// File: doc/BRIEF.md
# NOR Flash Block Erase Sequencer

This block runs one block erase on a parallel NOR flash that uses the six-write unlock command set. A single-cycle start pulse, with the block's byte offset and a cycle budget beside it, begins the operation. The sequencer then issues the unlock and erase writes on a simple request/acknowledge flash bus. After that it polls the device's status byte at the block offset until the erase finishes, the device reports an internal timeout, or the cycle budget runs out.

Completion is found by comparing consecutive status reads. While the erase runs, the device flips its status bit 6 on every read. When two reads in a row agree on that bit, the erase is over. If the bit is still flipping and the device also raises status bit 5, the sequencer takes two more reads. The outcome depends on whether bit 6 still flips between those two. A successful erase ends with a reset command to the device. Any outcome ends with a one-cycle done pulse and a two-bit result code.

The unlock addresses are word indices. They are shifted left by the `CMD_SHIFT` parameter (1 for a 16-bit part in byte mode). The erase confirm write uses the byte offset as given.

Top module: `nor_sector_erase`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done` and `fl_req` are 0 and `err` is 2'b00.
- R2: An accepted start issues seven writes, in this order and with `CMD_SHIFT`=1: 0xF0 to 0x000, 0xAA to 0xAAA, 0x55 to 0x554, 0x80 to 0xAAA, 0xAA to 0xAAA, 0x55 to 0x554, then 0x30 to the unshifted block offset.
- R3: A transfer holds `fl_req` with a stable `fl_we`, `fl_addr` and `fl_wdata` until `fl_ack` is seen at a clock edge. Read data is taken from `fl_rdata` in the acknowledge cycle. `fl_req` is 0 whenever `busy` is 0.
- R4: After the writes, all status reads (`fl_we`=0) go to the block offset. The first read is only stored. Each later read is compared with the one before it. Equal bit 6 means the erase succeeded.
- R5: If bit 6 differs and bit 5 of the newer read is 1, two more reads are taken. If their bit 6 differs, the result is device timeout. Otherwise the result is success.
- R6: Let c be the number of cycles from the first status read's acknowledge edge. If a compared read shows bit 6 differing, bit 5 clear, and c greater than the budget latched at start, the result is cycle timeout.
- R7: On success, one write of 0xF0 to address 0 follows the last read, and then done is raised. On either error, done follows the last read with no further transfer.
- R8: `done` is high for exactly one cycle. `busy` is high from the cycle after an accepted start through the done cycle. `err` holds the result from the done cycle until the next accepted start.
- R9: A start pulse while `busy` is 1 is ignored: it changes neither the offset used nor the number of operations.
- R10: The result codes are 2'b00 success, 2'b01 device timeout and 2'b10 cycle timeout. 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse, taken only when idle |
| blk_off | input | ADDR_W | Byte offset of the block to erase |
| tmo_limit | input | CNT_W | Cycle budget for status polling |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| err | output | 2 | Result code |
| fl_req | output | 1 | Flash transfer request |
| fl_we | output | 1 | 1 = write, 0 = read |
| fl_addr | output | ADDR_W | Flash byte address |
| fl_wdata | output | 8 | Write data |
| fl_ack | input | 1 | Transfer acknowledge |
| fl_rdata | input | 8 | Read data, valid with `fl_ack` |

## Verification
The assertions check the timing rules on every cycle:
- bus requests stay stable until acknowledged, and the bus is quiet while idle;
- `done` lasts a single cycle;
- a success ends right after the reset write, and an error ends right after a read;
- the result code never takes the unused value.

The decision logic can only be shown by the bench's scenarios. These sweep the number of toggling reads, the read on which the device raises its timeout flag, the bus wait states and the cycle budget. For each case the bench computes the expected result, the number of status reads and the full transfer log, and compares them with what the design did. Ignoring a start while busy is also shown by scenario, through the offset used and the done count.

// File: rtl/erase_pkg.sv
// Package: shared state type, result codes and status bit positions
// for the NOR block erase sequencer.
package erase_pkg;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_FIRST,
        ST_POLL,
        ST_RECHK0,
        ST_RECHK1,
        ST_RESET,
        ST_DONE
    } erase_state_t;

    localparam logic [1:0] RES_OK  = 2'b00;
    localparam logic [1:0] RES_DEV = 2'b01;
    localparam logic [1:0] RES_CYC = 2'b10;

    localparam int CMD_STEPS  = 7;
    localparam int STEP_W     = $clog2(CMD_STEPS);
    localparam int TOGGLE_BIT = 6;
    localparam int DEVTMO_BIT = 5;

    localparam logic [7:0] CMD_RESET   = 8'hF0;
    localparam logic [7:0] CMD_CONFIRM = 8'h30;

endpackage

// File: rtl/erase_cmd_table.sv
// Module: erase_cmd_table
// Maps a command step index to the address and data of that write.
// Steps 0..5 are reset plus unlock writes. Their word index is shifted
// by CMD_SHIFT. Step 6 is the erase confirm at the raw block offset.
// Assumes step never exceeds CMD_STEPS-1.
module erase_cmd_table
    import erase_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int CMD_SHIFT = 1
) (
    input  logic [STEP_W-1:0] step,
    input  logic [ADDR_W-1:0] blk_off,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [7:0]        cmd_data
);

    localparam int IDX_W = 12;

    logic [IDX_W-1:0]  word_idx;
    logic [ADDR_W-1:0] shifted;

    // Select the word index and data byte for the current step
    always_comb begin
        word_idx = '0;
        cmd_data = CMD_RESET;
        case (step)
            3'd0: begin word_idx = 12'h000; cmd_data = CMD_RESET; end
            3'd1: begin word_idx = 12'h555; cmd_data = 8'hAA;     end
            3'd2: begin word_idx = 12'h2AA; cmd_data = 8'h55;     end
            3'd3: begin word_idx = 12'h555; cmd_data = 8'h80;     end
            3'd4: begin word_idx = 12'h555; cmd_data = 8'hAA;     end
            3'd5: begin word_idx = 12'h2AA; cmd_data = 8'h55;     end
            default: begin word_idx = '0;   cmd_data = CMD_CONFIRM; end
        endcase
    end

    generate
        if (CMD_SHIFT == 0) begin : g_noshift
            assign shifted = ADDR_W'(word_idx);
        end else begin : g_shift
            assign shifted = ADDR_W'(word_idx) << CMD_SHIFT;
        end
    endgenerate

    // Confirm step uses the unshifted byte offset
    always_comb begin
        cmd_addr = (step == STEP_W'(CMD_STEPS - 1)) ? blk_off : shifted;
    end

endmodule

// File: rtl/erase_status_eval.sv
// Module: erase_status_eval
// Compares a new status byte with the previous one. It flags a flipped
// busy-toggle bit and reports the device's internal timeout flag in the
// new byte. Purely combinational.
module erase_status_eval
    import erase_pkg::*;
(
    input  logic [7:0] prev_stat,
    input  logic [7:0] new_stat,
    output logic       toggling,
    output logic       dev_flag
);

    logic [7:0] diff;

    // Bitwise difference of consecutive reads and the two decision bits
    always_comb begin
        diff     = prev_stat ^ new_stat;
        toggling = diff[TOGGLE_BIT];
        dev_flag = new_stat[DEVTMO_BIT];
    end

endmodule

// File: rtl/erase_cycle_timer.sv
// Module: erase_cycle_timer
// Latches the polling budget on load. It restarts at 1 on clear, so its
// value equals the cycles elapsed since the clear edge. It counts up
// with saturation. Over is high while the elapsed count is above the
// budget.
module erase_cycle_timer #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] limit_in,
    input  logic             clear,
    output logic             over
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] limit_q;
    logic [CNT_W-1:0] cnt_q;

    // Budget register, captured when an operation starts
    always_ff @(posedge clk) begin
        if (!rst_n)    limit_q <= '0;
        else if (load) limit_q <= limit_in;
    end

    // Elapsed-cycle counter, saturating at all ones
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (clear)            cnt_q <= CNT_W'(1);
        else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
    end

    assign over = (cnt_q > limit_q);

endmodule

// File: rtl/nor_sector_erase.sv
// Module: nor_sector_erase (top)
// Runs one NOR block erase: unlock writes, erase confirm, then status
// polling by toggle comparison with device and cycle timeouts. Bus rule:
// a transfer completes at the edge where fl_req and fl_ack are both high.
// Read data is valid in that cycle. Start is taken only when idle.
module nor_sector_erase
    import erase_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int CNT_W     = 32,
    parameter int CMD_SHIFT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] blk_off,
    input  logic [CNT_W-1:0]  tmo_limit,
    output logic              busy,
    output logic              done,
    output logic [1:0]        err,
    output logic              fl_req,
    output logic              fl_we,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [7:0]        fl_wdata,
    input  logic              fl_ack,
    input  logic [7:0]        fl_rdata
);

    erase_state_t      state_q;
    logic [STEP_W-1:0] step_q;
    logic [ADDR_W-1:0] off_q;
    logic [7:0]        prev_q;
    logic [1:0]        res_q;

    logic [ADDR_W-1:0] tbl_addr;
    logic [7:0]        tbl_data;
    logic              toggling;
    logic              dev_flag;
    logic              tmr_over;
    logic              accept;
    logic              xfer;

    assign accept = (state_q == ST_IDLE) && start;
    assign xfer   = fl_req && fl_ack;

    erase_cmd_table #(
        .ADDR_W    (ADDR_W),
        .CMD_SHIFT (CMD_SHIFT)
    ) u_tbl (
        .step     (step_q),
        .blk_off  (off_q),
        .cmd_addr (tbl_addr),
        .cmd_data (tbl_data)
    );

    erase_status_eval u_eval (
        .prev_stat (prev_q),
        .new_stat  (fl_rdata),
        .toggling  (toggling),
        .dev_flag  (dev_flag)
    );

    erase_cycle_timer #(
        .CNT_W (CNT_W)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .limit_in (tmo_limit),
        .clear    ((state_q == ST_FIRST) && xfer),
        .over     (tmr_over)
    );

    // Bus drive decoded from the current state
    always_comb begin
        fl_req   = 1'b0;
        fl_we    = 1'b0;
        fl_addr  = off_q;
        fl_wdata = 8'h00;
        case (state_q)
            ST_CMD: begin
                fl_req   = 1'b1;
                fl_we    = 1'b1;
                fl_addr  = tbl_addr;
                fl_wdata = tbl_data;
            end
            ST_FIRST, ST_POLL, ST_RECHK0, ST_RECHK1: begin
                fl_req = 1'b1;
            end
            ST_RESET: begin
                fl_req   = 1'b1;
                fl_we    = 1'b1;
                fl_addr  = '0;
                fl_wdata = CMD_RESET;
            end
            default: ;
        endcase
    end

    // Sequencer state, command step and result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            res_q   <= RES_OK;
        end else begin
            case (state_q)
                ST_IDLE: if (start) begin
                    state_q <= ST_CMD;
                    step_q  <= '0;
                    res_q   <= RES_OK;
                end
                ST_CMD: if (xfer) begin
                    if (step_q == STEP_W'(CMD_STEPS - 1)) state_q <= ST_FIRST;
                    else                                 step_q  <= step_q + 1'b1;
                end
                ST_FIRST: if (xfer) state_q <= ST_POLL;
                ST_POLL: if (xfer) begin
                    if (!toggling)     state_q <= ST_RESET;
                    else if (dev_flag) state_q <= ST_RECHK0;
                    else if (tmr_over) begin
                        state_q <= ST_DONE;
                        res_q   <= RES_CYC;
                    end
                end
                ST_RECHK0: if (xfer) state_q <= ST_RECHK1;
                ST_RECHK1: if (xfer) begin
                    if (toggling) begin
                        state_q <= ST_DONE;
                        res_q   <= RES_DEV;
                    end else begin
                        state_q <= ST_RESET;
                    end
                end
                ST_RESET: if (xfer) state_q <= ST_DONE;
                ST_DONE:  state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Block offset captured on an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n)      off_q <= '0;
        else if (accept) off_q <= blk_off;
    end

    // Previous status byte, updated on every status read
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else if (xfer && !fl_we) prev_q <= fl_rdata;
    end

    assign busy = (state_q != ST_IDLE);
    assign done = (state_q == ST_DONE);
    assign err  = res_q;

endmodule

// File: rtl/erase_checker.sv
// Module: erase_checker
// Cycle-level properties of nor_sector_erase, observed at its ports.
// Bound to every instance of the top module.
module erase_checker #(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [1:0]        err,
    input logic              fl_req,
    input logic              fl_we,
    input logic [ADDR_W-1:0] fl_addr,
    input logic [7:0]        fl_wdata,
    input logic              fl_ack
);

    // R3: an unacknowledged request stays put
    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && !fl_ack) |=> (fl_req && $stable(fl_we) && $stable(fl_addr) && $stable(fl_wdata)));

    // R3: no bus activity while idle
    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !fl_req);

    // R8: done lasts one cycle
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: a start while idle makes the block busy
    assert_start_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R7: success ends right after the reset write
    assert_ok_after_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err == 2'b00) |-> $past(fl_req && fl_ack && fl_we && fl_addr == '0 && fl_wdata == 8'hF0));

    // R7: errors end right after a status read
    assert_err_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err != 2'b00) |-> $past(fl_req && fl_ack && !fl_we));

    // R10: unused result code never appears
    assert_code_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err != 2'b11);

endmodule

bind nor_sector_erase erase_checker #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .fl_req   (fl_req),
    .fl_we    (fl_we),
    .fl_addr  (fl_addr),
    .fl_wdata (fl_wdata),
    .fl_ack   (fl_ack)
);

// File: tb/sim_nor_sector_erase.sv
module sim_nor_sector_erase;

    localparam int AW = 24;
    localparam int CW = 32;
    localparam int LOGN = 64;
    localparam int NEVER = 1000000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] blk_off = '0;
    logic [CW-1:0] tmo_limit = '0;
    logic          busy, done;
    logic [1:0]    err;
    logic          fl_req, fl_we;
    logic [AW-1:0] fl_addr;
    logic [7:0]    fl_wdata;
    logic          fl_ack = 1'b0;
    logic [7:0]    fl_rdata = 8'h00;

    nor_sector_erase #(.ADDR_W(AW), .CNT_W(CW), .CMD_SHIFT(1)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .blk_off(blk_off),
        .tmo_limit(tmo_limit), .busy(busy), .done(done), .err(err),
        .fl_req(fl_req), .fl_we(fl_we), .fl_addr(fl_addr),
        .fl_wdata(fl_wdata), .fl_ack(fl_ack), .fl_rdata(fl_rdata)
    );

    always #5 clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 0;

    // flash model settings and logs
    int m_wait = 0;
    int m_ntog = 0;
    int m_d5 = NEVER;
    int wcnt = 0;
    int rd_i = 0;
    int log_n = 0;
    logic          lg_we[LOGN];
    logic [AW-1:0] lg_addr[LOGN];
    logic [7:0]    lg_data[LOGN];
    int done_cnt = 0;
    logic [1:0] done_err = 2'b00;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] stat_byte(input int i);
        int t;
        logic [7:0] s;
        t = (i < m_ntog) ? i : m_ntog;
        s = 8'h00;
        s[6] = t[0];
        s[5] = (i >= m_d5);
        return s;
    endfunction

    // flash model: acknowledges after m_wait extra cycles, logs each transfer
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (done) begin
                done_cnt++;
                done_err = err;
            end
            if (!rst_n || !fl_req) begin
                fl_ack = 1'b0;
                wcnt = 0;
            end else if (wcnt == m_wait) begin
                fl_ack = 1'b1;
                wcnt = 0;
                if (log_n < LOGN) begin
                    lg_we[log_n] = fl_we;
                    lg_addr[log_n] = fl_addr;
                    lg_data[log_n] = fl_wdata;
                end
                log_n++;
                if (!fl_we) begin
                    fl_rdata = stat_byte(rd_i);
                    rd_i++;
                end
            end else begin
                fl_ack = 1'b0;
                wcnt++;
            end
        end
    end

    // watchdog
    initial begin
        wait (cyc > 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // expected outcome from R4, R5, R6
    task automatic expect_of(input int ntog, input int d5, input int w, input int lim,
                             output logic [1:0] res, output int reads);
        int k;
        k = 1;
        forever begin
            if (!(k <= ntog)) begin res = 2'b00; reads = k + 1; return; end
            if (k >= d5) begin
                res = ((k + 2) <= ntog) ? 2'b01 : 2'b00;
                reads = k + 3;
                return;
            end
            if ((w + 1) * k > lim) begin res = 2'b10; reads = k + 1; return; end
            k++;
        end
    endtask

    task automatic run(input logic [AW-1:0] off, input int ntog, input int d5,
                       input int w, input int lim, input bit poke);
        logic [1:0] eres;
        int ereads;
        int etotal;
        logic [AW-1:0] cmd_a[6];
        logic [7:0] cmd_d[6];
        cmd_a = '{24'h000, 24'hAAA, 24'h554, 24'hAAA, 24'hAAA, 24'h554};
        cmd_d = '{8'hF0, 8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55};
        expect_of(ntog, d5, w, lim, eres, ereads);
        m_wait = w; m_ntog = ntog; m_d5 = d5;
        rd_i = 0; log_n = 0; done_cnt = 0;
        @(negedge clk);
        blk_off = off; tmo_limit = CW'(lim); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R8 busy after start", busy, 1);
        if (poke) begin
            repeat (3) @(negedge clk);
            blk_off = ~off; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (done_cnt == 0) @(negedge clk);
        chk(busy == 1'b1, "R8 busy in done cycle", busy, 1);
        @(negedge clk);
        chk(busy == 1'b0, "R8 idle after done", busy, 0);
        chk(err == eres, "R8 err held", err, eres);
        repeat (3) @(negedge clk);
        chk(done_cnt == 1, "R8 R9 done count", done_cnt, 1);
        chk(done_err == eres, eres == 2'b01 ? "R5 result" : (eres == 2'b10 ? "R6 R10 result" : "R4 R10 result"),
            done_err, eres);
        chk(rd_i == ereads, "R4 R5 status read count", rd_i, ereads);
        etotal = 7 + ereads + ((eres == 2'b00) ? 1 : 0);
        chk(log_n == etotal, "R7 transfer count", log_n, etotal);
        for (int i = 0; i < 6; i++) begin
            chk(lg_we[i] && lg_addr[i] == cmd_a[i] && lg_data[i] == cmd_d[i], "R2 unlock write",
                {lg_we[i], lg_addr[i], lg_data[i]}, {1'b1, cmd_a[i], cmd_d[i]});
        end
        chk(lg_we[6] && lg_addr[6] == off && lg_data[6] == 8'h30, "R2 confirm write",
            {lg_we[6], lg_addr[6], lg_data[6]}, {1'b1, off, 8'h30});
        for (int i = 7; i < 7 + ereads && i < LOGN; i++) begin
            chk(!lg_we[i] && lg_addr[i] == off, poke ? "R9 offset kept" : "R4 read address",
                {lg_we[i], lg_addr[i]}, {1'b0, off});
        end
        if (eres == 2'b00 && etotal <= LOGN) begin
            chk(lg_we[etotal-1] && lg_addr[etotal-1] == '0 && lg_data[etotal-1] == 8'hF0,
                "R7 reset write", {lg_we[etotal-1], lg_addr[etotal-1], lg_data[etotal-1]},
                {1'b1, 24'h0, 8'hF0});
        end
    endtask

    initial begin
        logic [AW-1:0] offs[3];
        offs = '{24'h000100, 24'h01F000, 24'hFFFF80};
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0 && fl_req == 1'b0 && err == 2'b00, "R1 reset state",
            {busy, done, fl_req, err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && fl_req == 1'b0, "R1 idle after reset", {busy, fl_req}, 0);
        // sweep of toggle count, device-flag read and wait states (R3 via waits)
        for (int nt = 0; nt <= 4; nt++) begin
            for (int d = 1; d <= 6; d++) begin
                for (int w = 0; w <= 2; w++) begin
                    run(offs[(nt + d + w) % 3], nt, (d == 6) ? NEVER : d, w, 1000, 1'b0);
                end
            end
        end
        // cycle budget boundaries with a device that never finishes (R6)
        for (int w = 0; w <= 2; w++) begin
            run(offs[w], NEVER, NEVER, w, 0, 1'b0);
            run(offs[w], NEVER, NEVER, w, 3, 1'b0);
            run(offs[w], NEVER, NEVER, w, 5, 1'b0);
            run(offs[w], NEVER, NEVER, w, 17, 1'b0);
        end
        // start while busy is ignored (R9)
        run(24'h004000, 4, NEVER, 1, 1000, 1'b1);
        run(24'h008000, NEVER, NEVER, 0, 10, 1'b1);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule